// File: doc/BRIEF.md
# Banked Configuration Register File

This block holds the setup registers of a multi-function peripheral chip. The host reaches it through two byte-wide ports selected by `port_sel_i`. A write to the index port names a register. A data-port access then reads or writes that register. A device-select register at index 0x07 picks one of eight banks, and every data access at index 0x30 or above goes to the selected bank. Each bank holds an enable bit, one or two 16-bit I/O base addresses and up to two interrupt-select bytes. All bank contents are driven as outputs to the peripheral blocks.

The registers can be reached only in a configuration state. A fixed key written to the index port enters that state, and a second key leaves it. Per-bank masks, given as parameters, say which optional registers each bank has. Missing or reserved locations read as zero and drop writes. A synchronous reset clears everything. A separate soft-reset input restores the bank contents to their defaults and leaves the port state alone.

Top module: `cfg_bank_regs`

## Requirements
- R1: After `rst` the block is out of configuration mode, `rdata_o` is 0x00, the index and device-select registers are 0x00, and every bank output holds its default: interrupt select 0x06 for bank 0 and 0x00 for every other register of every bank.
- R2: Out of configuration mode, an index-port write of 0x55 enters the mode and any other index-port write has no effect. In the mode, an index-port write of 0xAA leaves it and any other value becomes the index. An index-port read returns the index while in the mode and 0xFF outside it.
- R3: Out of configuration mode, data-port writes change no register and data-port reads return 0xFF.
- R4: In configuration mode the device-select register at index 0x07 is written and read through the data port. A value of 8 or more selects no bank: bank locations then read 0x00 and writes to them are dropped.
- R5: Index 0x30 bit 0 is the enable bit of the selected bank and drives that bank's bit of `dev_active_o`. Bits 7:1 read as 0.
- R6: Indices 0x60 and 0x61 hold bits 15:8 and 7:0 of the bank's first base address, which is driven on that bank's 16-bit slice of `dev_base0_o`.
- R7: Indices 0x62 and 0x63 (high and low byte) hold a second base address only in banks 1 and 2. In every other bank they read 0 and ignore writes, and that bank's `dev_base1_o` slice stays 0.
- R8: Index 0x70 is the first interrupt select in every bank (`dev_irq0_o`). Index 0x72 is a second interrupt select that exists only in bank 4 (`dev_irq1_o`). It reads 0 and ignores writes in the other banks.
- R9: Every other bank location, including 0x31–0x5F, 0x71 and 0x73, reads 0x00 and ignores writes.
- R10: A one-cycle `soft_rst_i` pulse returns every bank register to its R1 default. It leaves the configuration mode, the index and the device-select register unchanged.
- R11: A read strobe sampled at a clock edge updates `rdata_o` at that edge, and `rdata_o` holds its value while no read is strobed. A bank output changes at the edge that samples the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Restore bank defaults |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| port_sel_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered host read data |
| cfg_mode_o | output | 1 | Configuration mode active |
| dev_active_o | output | 8 | Enable bit per bank |
| dev_base0_o | output | 128 | First base address, 16 bits per bank |
| dev_base1_o | output | 128 | Second base address, 16 bits per bank |
| dev_irq0_o | output | 64 | First interrupt select, 8 bits per bank |
| dev_irq1_o | output | 64 | Second interrupt select, 8 bits per bank |

## Verification
Configuration mode, the index, the device-select register and every bank output change at the clock edge that samples the write. Read data appears in `rdata_o` at the edge that samples the read strobe. The bench drives each access on a falling edge and steps its behavioural model 1 ns after the next rising edge. It compares all outputs against that model on every falling edge, so every comparison happens exactly one sampling edge after the stimulus. Explicit read-back checks use the same timing, and no write ever shares a cycle with a read, so the expected read value never depends on an update in the same cycle.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;

  typedef logic [BYTE_W-1:0] byte_t;

  // register indices whose decode drives behaviour
  localparam byte_t IDX_DEVSEL  = 8'h07;
  localparam byte_t IDX_BANKLO  = 8'h30;
  localparam byte_t IDX_ENABLE  = 8'h30;
  localparam byte_t IDX_B0_HI   = 8'h60;
  localparam byte_t IDX_B0_LO   = 8'h61;
  localparam byte_t IDX_B1_HI   = 8'h62;
  localparam byte_t IDX_B1_LO   = 8'h63;
  localparam byte_t IDX_IRQ_A   = 8'h70;
  localparam byte_t IDX_IRQ_B   = 8'h72;
  localparam byte_t RD_LOCKED   = 8'hFF;

  typedef struct packed {
    logic  en;
    byte_t addr;
    byte_t data;
  } bank_wr_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int    NDEV      = 8,
  parameter byte_t KEY_ENTER = 8'h55,
  parameter byte_t KEY_EXIT  = 8'hAA
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            port_sel_i,
  input  byte_t           wdata_i,
  output logic            cfg_mode_o,
  output byte_t           index_o,
  output byte_t           devsel_o,
  output bank_wr_t        bank_wr_o,
  output logic [NDEV-1:0] bank_sel_o
);
  logic idx_wr, dat_wr;

  assign idx_wr = wr_en_i && !port_sel_i;
  assign dat_wr = wr_en_i &&  port_sel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mode_o <= 1'b0;
      index_o    <= '0;
      devsel_o   <= '0;
    end else begin
      if (idx_wr) begin
        if (!cfg_mode_o) begin
          if (wdata_i == KEY_ENTER) cfg_mode_o <= 1'b1;
        end else if (wdata_i == KEY_EXIT) begin
          cfg_mode_o <= 1'b0;
        end else begin
          index_o <= wdata_i;
        end
      end
      if (dat_wr && cfg_mode_o && index_o == IDX_DEVSEL)
        devsel_o <= wdata_i;
    end
  end

  always_comb begin
    bank_wr_o.en   = dat_wr && cfg_mode_o && (index_o >= IDX_BANKLO);
    bank_wr_o.addr = index_o;
    bank_wr_o.data = wdata_i;
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_sel
    assign bank_sel_o[g] = (devsel_o == BYTE_W'(g));
  end
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_bank_pkg::*;
#(
  parameter bit    HAS_BASE1 = 1'b0,
  parameter bit    HAS_IRQ_B = 1'b0,
  parameter byte_t IRQ_A_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  byte_t             addr_i,
  input  byte_t             wdata_i,
  input  byte_t             rd_addr_i,
  output byte_t             rd_data_o,
  output logic              active_o,
  output logic [BASE_W-1:0] base0_o,
  output logic [BASE_W-1:0] base1_o,
  output byte_t             irq_a_o,
  output byte_t             irq_b_o
);
  logic clr;
  assign clr = rst || soft_rst_i;

  always_ff @(posedge clk) begin
    if (clr) begin
      active_o <= 1'b0;
      base0_o  <= '0;
      irq_a_o  <= IRQ_A_RST;
    end else if (we_i) begin
      case (addr_i)
        IDX_ENABLE: active_o       <= wdata_i[0];
        IDX_B0_HI:  base0_o[15:8]  <= wdata_i;
        IDX_B0_LO:  base0_o[7:0]   <= wdata_i;
        IDX_IRQ_A:  irq_a_o        <= wdata_i;
        default: ;
      endcase
    end
  end

  if (HAS_BASE1) begin : g_base1
    always_ff @(posedge clk) begin
      if (clr) begin
        base1_o <= '0;
      end else if (we_i) begin
        if (addr_i == IDX_B1_HI) base1_o[15:8] <= wdata_i;
        if (addr_i == IDX_B1_LO) base1_o[7:0]  <= wdata_i;
      end
    end
  end else begin : g_no_base1
    assign base1_o = '0;
  end

  if (HAS_IRQ_B) begin : g_irq_b
    always_ff @(posedge clk) begin
      if (clr)                              irq_b_o <= '0;
      else if (we_i && addr_i == IDX_IRQ_B) irq_b_o <= wdata_i;
    end
  end else begin : g_no_irq_b
    assign irq_b_o = '0;
  end

  always_comb begin
    case (rd_addr_i)
      IDX_ENABLE: rd_data_o = {7'b0, active_o};
      IDX_B0_HI:  rd_data_o = base0_o[15:8];
      IDX_B0_LO:  rd_data_o = base0_o[7:0];
      IDX_B1_HI:  rd_data_o = base1_o[15:8];
      IDX_B1_LO:  rd_data_o = base1_o[7:0];
      IDX_IRQ_A:  rd_data_o = irq_a_o;
      IDX_IRQ_B:  rd_data_o = irq_b_o;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
#(
  parameter int NDEV = 8,
  localparam int RDW = NDEV * BYTE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en_i,
  input  logic           port_sel_i,
  input  logic           cfg_mode_i,
  input  byte_t          index_i,
  input  byte_t          devsel_i,
  input  logic [RDW-1:0] bank_rd_i,
  output byte_t          rdata_o
);
  byte_t bank_byte, rd_next;

  always_comb begin
    bank_byte = '0;
    for (int g = 0; g < NDEV; g++)
      if (devsel_i == BYTE_W'(g)) bank_byte = bank_rd_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (!port_sel_i)               rd_next = cfg_mode_i ? index_i : RD_LOCKED;
    else if (!cfg_mode_i)          rd_next = RD_LOCKED;
    else if (index_i == IDX_DEVSEL) rd_next = devsel_i;
    else if (index_i >= IDX_BANKLO) rd_next = bank_byte;
    else                           rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
  import cfg_bank_pkg::*;
#(
  parameter int                 NDEV       = 8,
  parameter byte_t              KEY_ENTER  = 8'h55,
  parameter byte_t              KEY_EXIT   = 8'hAA,
  parameter logic [NDEV-1:0]    BASE1_MASK = 8'b0000_0110,
  parameter logic [NDEV-1:0]    IRQB_MASK  = 8'b0001_0000,
  parameter logic [NDEV*8-1:0]  IRQA_RST   = 64'h06
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     soft_rst_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic                     port_sel_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o,
  output logic                     cfg_mode_o,
  output logic [NDEV-1:0]          dev_active_o,
  output logic [NDEV*BASE_W-1:0]   dev_base0_o,
  output logic [NDEV*BASE_W-1:0]   dev_base1_o,
  output logic [NDEV*BYTE_W-1:0]   dev_irq0_o,
  output logic [NDEV*BYTE_W-1:0]   dev_irq1_o
);
  byte_t                 index_q, devsel_q;
  bank_wr_t              bank_wr;
  logic [NDEV-1:0]       bank_sel;
  logic [NDEV*BYTE_W-1:0] bank_rd;

  cfg_port_ctrl #(
    .NDEV(NDEV), .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .port_sel_i(port_sel_i),
    .wdata_i(wdata_i), .cfg_mode_o(cfg_mode_o), .index_o(index_q),
    .devsel_o(devsel_q), .bank_wr_o(bank_wr), .bank_sel_o(bank_sel)
  );

  for (genvar g = 0; g < NDEV; g++) begin : g_bank
    cfg_dev_bank #(
      .HAS_BASE1(BASE1_MASK[g]),
      .HAS_IRQ_B(IRQB_MASK[g]),
      .IRQ_A_RST(IRQA_RST[g*8 +: 8])
    ) bank_i (
      .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i),
      .we_i(bank_wr.en && bank_sel[g]),
      .addr_i(bank_wr.addr), .wdata_i(bank_wr.data),
      .rd_addr_i(index_q),
      .rd_data_o(bank_rd[g*BYTE_W +: BYTE_W]),
      .active_o(dev_active_o[g]),
      .base0_o(dev_base0_o[g*BASE_W +: BASE_W]),
      .base1_o(dev_base1_o[g*BASE_W +: BASE_W]),
      .irq_a_o(dev_irq0_o[g*BYTE_W +: BYTE_W]),
      .irq_b_o(dev_irq1_o[g*BYTE_W +: BYTE_W])
    );
  end

  cfg_read_mux #(.NDEV(NDEV)) rmux_i (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .port_sel_i(port_sel_i),
    .cfg_mode_i(cfg_mode_o), .index_i(index_q), .devsel_i(devsel_q),
    .bank_rd_i(bank_rd), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/cfg_bank_regs_chk.sv
module cfg_bank_regs_chk
  import cfg_bank_pkg::*;
#(
  parameter int NDEV = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   soft_rst_i,
  input logic                   wr_en_i,
  input logic                   rd_en_i,
  input logic                   port_sel_i,
  input logic [7:0]             wdata_i,
  input logic [7:0]             rdata_o,
  input logic                   cfg_mode_o,
  input logic [NDEV-1:0]        dev_active_o,
  input logic [NDEV*BASE_W-1:0] dev_base0_o,
  input logic [NDEV*BYTE_W-1:0] dev_irq0_o
);
  assert_enter_key_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode_o && wr_en_i && !port_sel_i && wdata_i == 8'h55) |=> cfg_mode_o);

  assert_exit_key_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode_o && wr_en_i && !port_sel_i && wdata_i == 8'hAA) |=> !cfg_mode_o);

  assert_idx_read_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode_o && rd_en_i && !port_sel_i) |=> rdata_o == 8'hFF);

  assert_locked_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode_o && !soft_rst_i) |=>
      ($stable(dev_active_o) && $stable(dev_base0_o) && $stable(dev_irq0_o)));

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode_o && rd_en_i && port_sel_i) |=> rdata_o == 8'hFF);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind cfg_bank_regs cfg_bank_regs_chk #(.NDEV(NDEV)) chk_i (
  .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .port_sel_i(port_sel_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .cfg_mode_o(cfg_mode_o), .dev_active_o(dev_active_o),
  .dev_base0_o(dev_base0_o), .dev_irq0_o(dev_irq0_o)
);

// File: tb/cfg_bank_regs_tb_top.sv
module cfg_bank_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         soft_rst_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic         port_sel_i = 1'b0;
  logic [7:0]   wdata_i = '0;
  logic [7:0]   rdata_o;
  logic         cfg_mode_o;
  logic [7:0]   dev_active_o;
  logic [127:0] dev_base0_o, dev_base1_o;
  logic [63:0]  dev_irq0_o, dev_irq1_o;

  always #4 clk = ~clk;

  cfg_bank_regs dut_i (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .port_sel_i(port_sel_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .cfg_mode_o(cfg_mode_o), .dev_active_o(dev_active_o),
    .dev_base0_o(dev_base0_o), .dev_base1_o(dev_base1_o),
    .dev_irq0_o(dev_irq0_o), .dev_irq1_o(dev_irq1_o)
  );

  // reference model state
  int m_act[8], m_b0[8], m_b1[8], m_i0[8], m_i1[8];
  int m_cfg, m_idx, m_dev, m_rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  function automatic bit has_b1(int d); return (d == 1 || d == 2); endfunction
  function automatic bit has_i1(int d); return (d == 4); endfunction

  function automatic void model_bank_defaults();
    for (int d = 0; d < 8; d++) begin
      m_act[d] = 0; m_b0[d] = 0; m_b1[d] = 0; m_i1[d] = 0;
      m_i0[d] = (d == 0) ? 'h06 : 0;
    end
  endfunction

  function automatic int model_read(bit port);
    int d;
    if (!port) return m_cfg ? m_idx : 'hFF;
    if (!m_cfg) return 'hFF;
    if (m_idx == 'h07) return m_dev;
    if (m_idx < 'h30 || m_dev >= 8) return 0;
    d = m_dev;
    case (m_idx)
      'h30: return m_act[d];
      'h60: return (m_b0[d] >> 8) & 'hFF;
      'h61: return m_b0[d] & 'hFF;
      'h62: return has_b1(d) ? (m_b1[d] >> 8) & 'hFF : 0;
      'h63: return has_b1(d) ? m_b1[d] & 'hFF : 0;
      'h70: return m_i0[d];
      'h72: return has_i1(d) ? m_i1[d] : 0;
      default: return 0;
    endcase
  endfunction

  function automatic void model_write(bit port, int v);
    int d;
    if (!port) begin
      if (!m_cfg) begin if (v == 'h55) m_cfg = 1; end
      else if (v == 'hAA) m_cfg = 0;
      else m_idx = v;
      return;
    end
    if (!m_cfg) return;
    if (m_idx == 'h07) begin m_dev = v; return; end
    if (m_dev >= 8) return;
    d = m_dev;
    case (m_idx)
      'h30: m_act[d] = v & 1;
      'h60: m_b0[d] = (m_b0[d] & 'hFF) | (v << 8);
      'h61: m_b0[d] = (m_b0[d] & 'hFF00) | v;
      'h62: if (has_b1(d)) m_b1[d] = (m_b1[d] & 'hFF) | (v << 8);
      'h63: if (has_b1(d)) m_b1[d] = (m_b1[d] & 'hFF00) | v;
      'h70: m_i0[d] = v;
      'h72: if (has_i1(d)) m_i1[d] = v;
      default: ;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R11 timing, R5..R8 outputs)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 cfg_mode", int'(cfg_mode_o), m_cfg);
      chk("R11 rdata", int'(rdata_o), m_rdata);
      for (int d = 0; d < 8; d++) begin
        chk("R5 active", int'(dev_active_o[d]), m_act[d]);
        chk("R6 base0", int'(dev_base0_o[d*16 +: 16]), m_b0[d]);
        chk("R7 base1", int'(dev_base1_o[d*16 +: 16]), m_b1[d]);
        chk("R8 irq0", int'(dev_irq0_o[d*8 +: 8]), m_i0[d]);
        chk("R8 irq1", int'(dev_irq1_o[d*8 +: 8]), m_i1[d]);
      end
    end
  end

  task automatic wr(bit port, int v);
    @(negedge clk);
    wr_en_i = 1'b1; port_sel_i = port; wdata_i = 8'(v);
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    model_write(port, v);
  endtask

  task automatic rd(bit port, string tag, int exp);
    @(negedge clk);
    rd_en_i = 1'b1; port_sel_i = port;
    @(posedge clk); #1;
    rd_en_i = 1'b0;
    m_rdata = model_read(port);
    @(negedge clk);
    chk(tag, int'(rdata_o), exp);
  endtask

  task automatic wreg(int idx, int v);
    wr(1'b0, idx); wr(1'b1, v);
  endtask

  task automatic rreg(int idx, string tag, int exp);
    wr(1'b0, idx); rd(1'b1, tag, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_bank_defaults();
    m_cfg = 0; m_idx = 0; m_dev = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_mode", int'(cfg_mode_o), 0);
    chk("R1 rdata", int'(rdata_o), 0);
    chk("R1 irq0 bank0", int'(dev_irq0_o[7:0]), 'h06);
    chk("R1 active", int'(dev_active_o), 0);

    // R3 locked access, R2 locked index read and non-key write
    wr(1'b1, 'h12);
    rd(1'b1, "R3 locked data read", 'hFF);
    rd(1'b0, "R2 locked index read", 'hFF);
    wr(1'b0, 'h30);
    chk("R2 non-key ignored", int'(cfg_mode_o), 0);
    wr(1'b0, 'h55);
    chk("R2 enter", int'(cfg_mode_o), 1);
    rd(1'b0, "R2 index after entry", 'h00);

    // R4..R9 per bank
    for (int d = 0; d < 8; d++) begin
      wreg('h07, d);
      rreg('h07, "R4 devsel readback", d);
      wreg('h30, 'hFF);
      rreg('h30, "R5 enable bit only", 'h01);
      wreg('h60, 'hA0 + d);
      wreg('h61, 'h10 + d);
      rreg('h60, "R6 base0 high", 'hA0 + d);
      rreg('h61, "R6 base0 low", 'h10 + d);
      wreg('h62, 'hC0 + d);
      wreg('h63, 'h20 + d);
      rreg('h62, "R7 base1 high", (d == 1 || d == 2) ? 'hC0 + d : 0);
      rreg('h63, "R7 base1 low", (d == 1 || d == 2) ? 'h20 + d : 0);
      wreg('h70, 'h30 + d);
      wreg('h72, 'h40 + d);
      rreg('h70, "R8 irq0", 'h30 + d);
      rreg('h72, "R8 irq1", (d == 4) ? 'h44 : 0);
      wreg('h31, 'h5A); wreg('h45, 'h5A); wreg('h71, 'h5A); wreg('h73, 'h5A);
      rreg('h31, "R9 reserved 0x31", 0);
      rreg('h45, "R9 reserved 0x45", 0);
      rreg('h71, "R9 reserved 0x71", 0);
      rreg('h73, "R9 reserved 0x73", 0);
      if (d == 3) wreg('h30, 'h00);
    end
    rreg('h05, "R9 low global location", 0);

    // R4 out-of-range device number
    wreg('h07, 'h09);
    wreg('h70, 'h77);
    wreg('h30, 'h00);
    rreg('h70, "R4 no bank read", 0);
    rreg('h07, "R4 devsel 9 readback", 'h09);
    wreg('h07, 'h02);
    rreg('h70, "R4 dropped write kept", 'h32);

    // R2 exit, R3 writes blocked while locked
    wr(1'b0, 'h60);
    wr(1'b0, 'hAA);
    chk("R2 exit", int'(cfg_mode_o), 0);
    wr(1'b1, 'h99);
    rd(1'b1, "R3 locked read after exit", 'hFF);
    wr(1'b0, 'h55);
    rd(1'b0, "R2 index kept across exit", 'h60);
    rd(1'b1, "R3 locked write dropped", 'hA2);

    // R11 read data held without strobe
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", int'(rdata_o), 'hA2);

    // R10 soft reset
    @(negedge clk);
    soft_rst_i = 1'b1;
    @(posedge clk); #1;
    soft_rst_i = 1'b0;
    model_bank_defaults();
    @(negedge clk);
    chk("R10 cfg kept", int'(cfg_mode_o), 1);
    chk("R10 irq0 bank0 default", int'(dev_irq0_o[7:0]), 'h06);
    chk("R10 base0 cleared", int'(dev_base0_o), 0);
    rd(1'b0, "R10 index kept", 'h60);
    rreg('h07, "R10 devsel kept", 'h02);
    rreg('h62, "R10 base1 cleared", 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule